// File: doc/BRIEF.md
# Seeded Scaled-LFSR Line Offset Generator

This block produces a repeatable stream of pseudo-random line offsets for a video line shuffler. A 9-bit linear feedback shift register, started from a user seed, advances once per requested step. Its state is mapped into 359 possible values by a fixed-point multiply with truncation, and the result is padded with two zero bits, so every offset is a multiple of four no greater than 1436.

Two ends of a link, a scrambler and a descrambler, are given the same seed. Both stay in lockstep because each end restarts its sequence from the stored seed after a fixed group of 288 offsets and also whenever the field-change input pulses. The multiply and padding are registered in one stage, and a valid strobe marks each new offset. The offset distribution is not uniform, and the sequence is not meant to be secure.

Top module: `line_offset_gen`

## Requirements
- R1: While rst_ni is low and after it is released, valid_o is 0 and offset_o is 0. The internal register and the stored seed both reset to all ones (511).
- R2: Each accepted step advances the register state s to ((s << 1) & 511) | (s[8] ^ s[3]). Bits 7..0 move up one place and the feedback enters bit 0.
- R3: The offset for a step is floor(s * 719 / 1024) * 4, where s is the state before that step's advance. For example, state 504 gives 1412 and the state after it (496) gives 1392.
- R4: Every offset shown with valid_o high has bits 1..0 equal to zero and does not exceed 1436. The all-ones state gives the largest value, 1432.
- R5: A step accepted at a clock edge shows its offset on offset_o with valid_o high for exactly the following cycle. offset_o holds its last value while valid_o is low.
- R6: With step_i low and no load or restart, the state does not advance, valid_o stays low and offset_o is unchanged.
- R7: load_i stores seed_i as the seed, loads it into the register and clears the group count. A zero seed is replaced by 511.
- R8: After 288 outputs since the last load or restart, the register reloads from the stored seed. The next 288 offsets therefore repeat the previous 288.
- R9: restart_i reloads the register from the stored seed and clears the group count, so the following offsets repeat those produced right after the last load.
- R10: Priority is load_i over restart_i over step_i. A step in the same cycle as a load or a restart produces no output (valid_o is 0 in the next cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_i | input | 9 | Seed value captured on load_i |
| load_i | input | 1 | Store seed and start the sequence from it |
| restart_i | input | 1 | Field-change pulse; restart from stored seed |
| step_i | input | 1 | Advance one step and emit one offset |
| offset_o | output | 11 | Line offset, multiple of four |
| valid_o | output | 1 | High for one cycle when offset_o is new |

## Verification
On every cycle, the assertions check the following: offset range and alignment, that the register state is never zero, that the group count stays bounded, that a restart or group wrap returns the state to the stored seed, and that no valid appears without an accepted step. The bench scenarios are needed for the rest. They show the exact scaled values, such as the 504→1412 case, and that 288-offset groups repeat. They also show that a mid-group restart replays the sequence, that the zero-seed substitution works, and that the order of simultaneous controls is honoured. A behavioural model is compared on every cycle under long random control patterns.

// File: rtl/line_ofs_pkg.sv
package line_ofs_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE    = 2'd0,
    CMD_LOAD    = 2'd1,
    CMD_RESTART = 2'd2,
    CMD_STEP    = 2'd3
  } seq_cmd_e;
endpackage

// File: rtl/ofs_lfsr.sv
module ofs_lfsr
  import line_ofs_pkg::*;
#(
  parameter int W     = 9,
  parameter int TAP_A = 8,
  parameter int TAP_B = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  seq_cmd_e     cmd_i,
  input  logic         wrap_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] seed_q, state_q, seed_fix, state_nxt;
  logic         fb;

  assign seed_fix = (seed_i == '0) ? '1 : seed_i;  // zero would lock up
  assign fb       = state_q[TAP_A] ^ state_q[TAP_B];

  always_comb begin
    state_nxt = state_q;
    unique case (cmd_i)
      CMD_LOAD:    state_nxt = seed_fix;
      CMD_RESTART: state_nxt = seed_q;
      CMD_STEP:    state_nxt = wrap_i ? seed_q : {state_q[W-2:0], fb};
      default:     state_nxt = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q  <= '1;
      state_q <= '1;
    end else begin
      if (cmd_i == CMD_LOAD) seed_q <= seed_fix;
      state_q <= state_nxt;
    end
  end

  assign state_o = state_q;

  a_r7_state_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  a_r9_restart_to_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_RESTART) |=> (state_q == $past(seed_q)));
  a_r8_wrap_to_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_STEP && wrap_i) |=> (state_q == $past(seed_q)));
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_IDLE) |=> $stable(state_q));
endmodule

// File: rtl/ofs_group_cnt.sv
module ofs_group_cnt
  import line_ofs_pkg::*;
#(
  parameter int LEN = 288
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  seq_cmd_e cmd_i,
  output logic     wrap_o
);
  localparam int CNT_W = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == CNT_W'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (cmd_i)
        CMD_LOAD, CMD_RESTART: cnt_q <= '0;
        CMD_STEP:              cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
        default:               cnt_q <= cnt_q;
      endcase
    end
  end

  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < LEN);
  a_r9_count_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_LOAD || cmd_i == CMD_RESTART) |=> (cnt_q == '0));
endmodule

// File: rtl/ofs_scaler.sv
module ofs_scaler #(
  parameter int IN_W    = 9,
  parameter int SCALE   = 719,
  parameter int FRAC_W  = 10,
  parameter int PAD_W   = 2,
  parameter int MAX_OFS = 1436
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [IN_W-1:0]       state_i,
  output logic [IN_W+PAD_W-1:0] offset_o,
  output logic                  valid_o
);
  localparam int PROD_W = IN_W + FRAC_W;  // SCALE < 2**FRAC_W
  localparam int OUT_W  = IN_W + PAD_W;

  logic [IN_W-1:0]  scaled;
  logic [OUT_W-1:0] offset_q;
  logic             valid_q;

  assign scaled = IN_W'((PROD_W'(state_i) * PROD_W'(SCALE)) >> FRAC_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= en_i;
      if (en_i) offset_q <= {scaled, {PAD_W{1'b0}}};
    end
  end

  assign offset_o = offset_q;
  assign valid_o  = valid_q;

  a_r4_offset_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (int'(offset_q) <= MAX_OFS && offset_q[PAD_W-1:0] == '0));
  a_r5_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(offset_q));
endmodule

// File: rtl/line_offset_gen.sv
module line_offset_gen
  import line_ofs_pkg::*;
#(
  parameter int LFSR_W    = 9,
  parameter int TAP_A     = 8,
  parameter int TAP_B     = 3,
  parameter int SCALE     = 719,
  parameter int FRAC_W    = 10,
  parameter int PAD_W     = 2,
  parameter int GROUP_LEN = 288,
  parameter int MAX_OFS   = 1436
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LFSR_W-1:0]       seed_i,
  input  logic                    load_i,
  input  logic                    restart_i,
  input  logic                    step_i,
  output logic [LFSR_W+PAD_W-1:0] offset_o,
  output logic                    valid_o
);
  seq_cmd_e          cmd;
  logic              wrap;
  logic [LFSR_W-1:0] state;

  always_comb begin
    if (load_i)         cmd = CMD_LOAD;
    else if (restart_i) cmd = CMD_RESTART;
    else if (step_i)    cmd = CMD_STEP;
    else                cmd = CMD_IDLE;
  end

  ofs_lfsr #(.W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_lfsr (
    .clk_i, .rst_ni, .cmd_i(cmd), .wrap_i(wrap), .seed_i, .state_o(state)
  );

  ofs_group_cnt #(.LEN(GROUP_LEN)) u_cnt (
    .clk_i, .rst_ni, .cmd_i(cmd), .wrap_o(wrap)
  );

  ofs_scaler #(
    .IN_W(LFSR_W), .SCALE(SCALE), .FRAC_W(FRAC_W), .PAD_W(PAD_W), .MAX_OFS(MAX_OFS)
  ) u_scale (
    .clk_i, .rst_ni, .en_i(cmd == CMD_STEP), .state_i(state),
    .offset_o, .valid_o
  );

  a_r6_no_step_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> !valid_o);
  a_r10_load_blocks_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i || restart_i) |=> !valid_o);
endmodule

// File: tb/line_offset_gen_test.sv
module line_offset_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int GRP = 288;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  seed_i = '0;
  logic        load_i = 1'b0, restart_i = 1'b0, step_i = 1'b0;
  logic [10:0] offset_o;
  logic        valid_o;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  int m_state = 511, m_seed = 511, m_cnt = 0, m_off = 0;
  bit m_vld = 0;
  int log_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  line_offset_gen uut (
    .clk_i(clk), .rst_ni, .seed_i, .load_i, .restart_i, .step_i, .offset_o, .valid_o
  );

  function automatic int lfsr_next(int s);
    return ((s << 1) & 511) | (((s >> 8) ^ (s >> 3)) & 1);
  endfunction

  function automatic int scale_of(int s);
    return ((s * 719) / 1024) * 4;
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives at negedge, compares at the next negedge
  task automatic tick(bit ld, bit rs, bit st, int sd, string req);
    load_i = ld; restart_i = rs; step_i = st; seed_i = sd[8:0];
    m_vld = 0;
    if (ld) begin
      m_seed = (sd == 0) ? 511 : sd; m_state = m_seed; m_cnt = 0;
    end else if (rs) begin
      m_state = m_seed; m_cnt = 0;
    end else if (st) begin
      m_off = scale_of(m_state); m_vld = 1; m_cnt++;
      if (m_cnt == GRP) begin m_cnt = 0; m_state = m_seed; end
      else m_state = lfsr_next(m_state);
    end
    @(posedge clk); @(negedge clk);
    load_i = 0; restart_i = 0; step_i = 0;
    check({req, " R5 valid"}, int'(valid_o), int'(m_vld));
    check({req, " R3 offset"}, int'(offset_o), m_off);
    if (valid_o) begin
      log_q.push_back(int'(offset_o));
      if (offset_o > 11'd1436 || offset_o[1:0] != 2'b00) begin
        vectors++; miscompares++;
        $display("FAIL R4 actual=%0d expected=<=1436 and multiple of 4", offset_o);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(valid_o), 0);
    check("R1 offset in reset", int'(offset_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(valid_o), 0);
    check("R1 offset after reset", int'(offset_o), 0);

    // reset state is 511: first step gives the maximum
    tick(0, 0, 1, 0, "R1 reset seed");
    check("R4 max value", int'(offset_o), 1432);

    // worked example and feedback
    tick(1, 0, 0, 504, "R7 load");
    tick(0, 0, 1, 0, "R3");
    check("R3 state 504", int'(offset_o), 1412);
    tick(0, 0, 1, 0, "R2");
    check("R2 state 496", int'(offset_o), 1392);

    // idle: no advance, offset held
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, "R6 idle");
    check("R6 held offset", int'(offset_o), 1392);
    tick(0, 0, 1, 0, "R6 resume");
    check("R6 no advance while idle", int'(offset_o), scale_of(lfsr_next(496)));

    // zero seed substitutes all ones
    tick(1, 0, 0, 0, "R7 zero seed");
    tick(0, 0, 1, 0, "R7");
    check("R7 zero seed -> 511", int'(offset_o), 1432);

    // group repeat
    tick(1, 0, 0, 37, "R8 load");
    log_q.delete();
    for (int i = 0; i < 2 * GRP; i++) tick(0, 0, 1, 0, "R8");
    for (int i = 0; i < GRP; i += 41)
      check("R8 group repeat", log_q[i + GRP], log_q[i]);
    check("R8 last of group", log_q[2*GRP-1], log_q[GRP-1]);

    // restart replays
    tick(1, 0, 0, 301, "R9 load");
    log_q.delete();
    for (int i = 0; i < 6; i++) tick(0, 0, 1, 0, "R9");
    tick(0, 1, 0, 0, "R9 restart");
    for (int i = 0; i < 6; i++) tick(0, 0, 1, 0, "R9");
    for (int i = 0; i < 6; i++) check("R9 replay after restart", log_q[i + 6], log_q[i]);

    // priority
    tick(1, 0, 1, 100, "R10 load+step");
    check("R10 load+step no valid", int'(valid_o), 0);
    tick(0, 1, 1, 0, "R10 restart+step");
    check("R10 restart+step no valid", int'(valid_o), 0);
    tick(1, 1, 0, 222, "R10 load+restart");
    tick(0, 0, 1, 0, "R10");
    check("R10 load wins over restart", int'(offset_o), scale_of(222));

    // random control mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      tick(r < 2, (r >= 2 && r < 5), (r >= 20) || (r == 3), $urandom_range(0, 511), "R2 random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule